// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the 13-bit program counter of a small word-addressed processor. It also keeps a 5-bit page latch that holds the upper address bits for later use. The counter changes in one of four ways:

- it steps forward by one;
- software writes its low byte as the destination of a data operation;
- a jump or call loads an 11-bit immediate target;
- a return loads a complete 13-bit address that the surrounding core fetched from its call stack.

The upper counter bits never come from an instruction alone. A low-byte write takes all five upper bits from the page latch. A jump or call takes only the two top latch bits. A return ignores the latch and does not change it.

The unit sits between the instruction decoder, which raises the strobes, and the program memory, which the counter addresses. The stack, the decoder and the memory are outside this block. A computed table lookup works by writing a new low byte. There is no carry into bit 8, so such a lookup always stays inside the 256-word block that the latch selects.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter and the page latch both become zero after that edge.
- R2: `pc_lo` always equals bits 7:0 of `pc`.
- R3: A low-byte write loads `pc` with the page latch in bits 12:8 and `lo_wdata` in bits 7:0. The latch value used is the one held before the edge. No carry enters bit 8.
- R4: A jump or call loads `pc` with latch bits 4:3 in bits 12:11 and `jmp_tgt` in bits 10:0.
- R5: A return loads all 13 bits of `pc` from `ret_addr`. The page latch is left unchanged by it.
- R6: An increment with no load strobe active adds one to `pc`. The value 0x1FFF wraps to 0x0000.
- R7: With no strobe active, `pc` holds its value.
- R8: When strobes coincide, reset wins over return, return over jump, jump over low-byte write, and low-byte write over increment.
- R9: A latch write stores `lat_wdata` at the edge. A counter update in the same cycle still uses the previous latch value, and later updates use the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_en | input | 1 | Step the counter by one |
| lo_wr | input | 1 | Write the counter's low byte |
| lo_wdata | input | 8 | New low byte |
| jmp_en | input | 1 | Jump or call strobe |
| jmp_tgt | input | 11 | Immediate target from the instruction |
| ret_en | input | 1 | Return strobe |
| ret_addr | input | 13 | Full return address |
| lat_wr | input | 1 | Write the page latch |
| lat_wdata | input | 5 | New page latch value |
| pc | output | 13 | Current program counter |
| pc_lo | output | 8 | Readable low byte of the counter |

## Verification
Low-byte writes are swept over every latch value and every data byte. This shows that all five latch bits reach bits 12:8 and that no data bit leaks upward. Jumps run across all four page selections with a strided sweep of targets, which shows that the lower three latch bits do not affect the result. Returns are swept across the whole address space. A return with a nonzero latch, followed by a low-byte write, shows that the latch survived the return. All sixteen combinations of the four counter strobes are applied from a known state to separate each step of the priority order. Single increments cross 0x00FF and 0x1FFF, which distinguishes a normal carry into the upper bits from the wrap at the top.

// File: rtl/pcu_pkg.sv
// Package: shared sizes and the update-source encoding of the paged counter.
// Assumes: the default sizes describe a 13-bit counter with an 8-bit low byte.
package pcu_pkg;

    localparam int PCU_PC_W  = 13;
    localparam int PCU_LO_W  = 8;
    localparam int PCU_JMP_W = 11;

    // Selected source of the next counter value, chosen once per cycle.
    typedef enum logic [2:0] {
        SRC_HOLD = 3'd0,
        SRC_INC  = 3'd1,
        SRC_LO   = 3'd2,
        SRC_JMP  = 3'd3,
        SRC_RET  = 3'd4
    } pc_src_e;

endpackage

// File: rtl/pcu_latch.sv
// Module: page latch holding the upper address bits for later counter loads.
// Assumes: the write strobe is independent of the counter strobes; a write
// takes effect at the edge, so a same-cycle user sees the old contents.
module pcu_latch #(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LAT_W-1:0] wdata,
    output logic [LAT_W-1:0] lat_q
);

    // Store a new page value on request; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else if (wr_en) begin
            lat_q <= wdata;
        end
    end

endmodule

// File: rtl/pcu_sel.sv
// Module: fixed-priority choice of the counter update source.
// Assumes: reset is handled by the counter register itself; the order
// here is return, jump, low-byte write, increment, hold.
module pcu_sel
    import pcu_pkg::*;
(
    input  logic    inc_en,
    input  logic    lo_wr,
    input  logic    jmp_en,
    input  logic    ret_en,
    output pc_src_e src
);

    // Resolve concurrent strobes into exactly one source.
    always_comb begin
        if (ret_en) begin
            src = SRC_RET;
        end else if (jmp_en) begin
            src = SRC_JMP;
        end else if (lo_wr) begin
            src = SRC_LO;
        end else if (inc_en) begin
            src = SRC_INC;
        end else begin
            src = SRC_HOLD;
        end
    end

endmodule

// File: rtl/pcu_next.sv
// Module: builds the next counter value for the selected source.
// Assumes: LAT_W = PC_W - LO_W and the jump page field is the top
// PC_W - JMP_W bits of the latch.
module pcu_next
    import pcu_pkg::*;
#(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11
) (
    input  pc_src_e                 src,
    input  logic [PC_W-1:0]         pc_q,
    input  logic [PC_W-LO_W-1:0]    lat_q,
    input  logic [LO_W-1:0]         lo_wdata,
    input  logic [JMP_W-1:0]        jmp_tgt,
    input  logic [PC_W-1:0]         ret_addr,
    output logic [PC_W-1:0]         pc_d
);

    localparam int LAT_W  = PC_W - LO_W;
    localparam int PAGE_W = PC_W - JMP_W;

    logic [PC_W-1:0]   pc_inc;
    logic [PC_W-1:0]   pc_lo_ld;
    logic [PC_W-1:0]   pc_jmp;
    logic [PAGE_W-1:0] page_sel;

    // Candidate values, one per source; the increment wraps naturally.
    always_comb begin
        page_sel = lat_q[LAT_W-1 -: PAGE_W];
        pc_inc   = pc_q + PC_W'(1);
        pc_lo_ld = {lat_q, lo_wdata};
        pc_jmp   = {page_sel, jmp_tgt};
    end

    // Pick the candidate named by the source code.
    always_comb begin
        unique case (src)
            SRC_RET:  pc_d = ret_addr;
            SRC_JMP:  pc_d = pc_jmp;
            SRC_LO:   pc_d = pc_lo_ld;
            SRC_INC:  pc_d = pc_inc;
            default:  pc_d = pc_q;
        endcase
    end

endmodule

// File: rtl/paged_pc_unit.sv
// Module: top of the paged program counter unit.
// Assumes: strobes are single-cycle decoder outputs sampled at the rising
// edge; the stack that supplies ret_addr lives outside this block.
module paged_pc_unit
    import pcu_pkg::*;
#(
    parameter int PC_W  = PCU_PC_W,
    parameter int LO_W  = PCU_LO_W,
    parameter int JMP_W = PCU_JMP_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc_en,
    input  logic                  lo_wr,
    input  logic [LO_W-1:0]       lo_wdata,
    input  logic                  jmp_en,
    input  logic [JMP_W-1:0]      jmp_tgt,
    input  logic                  ret_en,
    input  logic [PC_W-1:0]       ret_addr,
    input  logic                  lat_wr,
    input  logic [PC_W-LO_W-1:0]  lat_wdata,
    output logic [PC_W-1:0]       pc,
    output logic [LO_W-1:0]       pc_lo
);

    localparam int LAT_W = PC_W - LO_W;

    logic [LAT_W-1:0] lat_q;
    logic [PC_W-1:0]  pc_q;
    logic [PC_W-1:0]  pc_d;
    pc_src_e          src;

    pcu_latch #(.LAT_W(LAT_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (lat_wr),
        .wdata (lat_wdata),
        .lat_q (lat_q)
    );

    pcu_sel u_sel (
        .inc_en (inc_en),
        .lo_wr  (lo_wr),
        .jmp_en (jmp_en),
        .ret_en (ret_en),
        .src    (src)
    );

    pcu_next #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W)) u_next (
        .src      (src),
        .pc_q     (pc_q),
        .lat_q    (lat_q),
        .lo_wdata (lo_wdata),
        .jmp_tgt  (jmp_tgt),
        .ret_addr (ret_addr),
        .pc_d     (pc_d)
    );

    // Counter register; reset outranks every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    // Expose the full counter and its readable low byte.
    always_comb begin
        pc    = pc_q;
        pc_lo = pc_q[LO_W-1:0];
    end

endmodule

// File: rtl/pcu_chk.sv
// Module: property checker for paged_pc_unit, bound to every instance.
// Assumes: it observes ports plus the internal page latch value.
module pcu_chk #(
    parameter int PC_W  = 13,
    parameter int LO_W  = 8,
    parameter int JMP_W = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 inc_en,
    input logic                 lo_wr,
    input logic [LO_W-1:0]      lo_wdata,
    input logic                 jmp_en,
    input logic [JMP_W-1:0]     jmp_tgt,
    input logic                 ret_en,
    input logic [PC_W-1:0]      ret_addr,
    input logic                 lat_wr,
    input logic [PC_W-1:0]      pc,
    input logic [PC_W-LO_W-1:0] lat_q
);

    localparam int LAT_W  = PC_W - LO_W;
    localparam int PAGE_W = PC_W - JMP_W;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && lat_q == '0)); // R1

    AST_LO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !jmp_en && !ret_en) |=>
        pc == {$past(lat_q), $past(lo_wdata)}); // R3

    AST_JMP_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (jmp_en && !ret_en) |=>
        pc == {$past(lat_q[LAT_W-1 -: PAGE_W]), $past(jmp_tgt)}); // R4

    AST_RET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ret_en |=> pc == $past(ret_addr)); // R5

    AST_RET_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !lat_wr) |=> $stable(lat_q)); // R5

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !lo_wr && !jmp_en && !ret_en) |=>
        pc == PC_W'($past(pc) + PC_W'(1))); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_en && !lo_wr && !jmp_en && !ret_en) |=> $stable(pc)); // R7

    AST_LATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lat_wr |=> $stable(lat_q)); // R9

endmodule

bind paged_pc_unit pcu_chk #(.PC_W(PC_W), .LO_W(LO_W), .JMP_W(JMP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc_en   (inc_en),
    .lo_wr    (lo_wr),
    .lo_wdata (lo_wdata),
    .jmp_en   (jmp_en),
    .jmp_tgt  (jmp_tgt),
    .ret_en   (ret_en),
    .ret_addr (ret_addr),
    .lat_wr   (lat_wr),
    .pc       (pc),
    .lat_q    (lat_q)
);

// File: tb/sim_paged_pc_unit.sv
// Bench: sweeps every update mode of paged_pc_unit against an arithmetic model.
module sim_paged_pc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_en = 1'b0;
    logic        lo_wr = 1'b0;
    logic [7:0]  lo_wdata = '0;
    logic        jmp_en = 1'b0;
    logic [10:0] jmp_tgt = '0;
    logic        ret_en = 1'b0;
    logic [12:0] ret_addr = '0;
    logic        lat_wr = 1'b0;
    logic [4:0]  lat_wdata = '0;
    logic [12:0] pc;
    logic [7:0]  pc_lo;

    logic [12:0] m_pc = '0;
    logic [4:0]  m_lat = '0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    paged_pc_unit u0 (
        .clk (clk), .rst_n (rst_n), .inc_en (inc_en), .lo_wr (lo_wr),
        .lo_wdata (lo_wdata), .jmp_en (jmp_en), .jmp_tgt (jmp_tgt),
        .ret_en (ret_en), .ret_addr (ret_addr), .lat_wr (lat_wr),
        .lat_wdata (lat_wdata), .pc (pc), .pc_lo (pc_lo)
    );

    task automatic check(input string tag);
        n_chk++;
        if (pc !== m_pc) begin
            n_fail++;
            $display("FAIL %s pc actual=%h expected=%h", tag, pc, m_pc);
        end
        n_chk++;
        if (pc_lo !== m_pc[7:0]) begin
            n_fail++;
            $display("FAIL R2 pc_lo actual=%h expected=%h", pc_lo, m_pc[7:0]);
        end
    endtask

    // One clock: drive at the falling edge, update model, sample after rise.
    task automatic step(input string tag, input logic rs, input logic i,
                        input logic l, input logic [7:0] ld,
                        input logic j, input logic [10:0] jt,
                        input logic r, input logic [12:0] ra,
                        input logic lw, input logic [4:0] lwd);
        @(negedge clk);
        rst_n = rs; inc_en = i; lo_wr = l; lo_wdata = ld; jmp_en = j;
        jmp_tgt = jt; ret_en = r; ret_addr = ra; lat_wr = lw; lat_wdata = lwd;
        if (!rs) begin
            m_pc = '0; m_lat = '0;
        end else begin
            if (r)      m_pc = ra;
            else if (j) m_pc = {m_lat[4:3], jt};
            else if (l) m_pc = {m_lat, ld};
            else if (i) m_pc = m_pc + 13'd1;
            if (lw) m_lat = lwd;
        end
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic do_lo(input string tag, input logic [7:0] d);
        step(tag, 1, 0, 1, d, 0, '0, 0, '0, 0, '0);
    endtask
    task automatic do_jmp(input string tag, input logic [10:0] t);
        step(tag, 1, 0, 0, '0, 1, t, 0, '0, 0, '0);
    endtask
    task automatic do_ret(input string tag, input logic [12:0] a);
        step(tag, 1, 0, 0, '0, 0, '0, 1, a, 0, '0);
    endtask
    task automatic do_inc(input string tag);
        step(tag, 1, 1, 0, '0, 0, '0, 0, '0, 0, '0);
    endtask
    task automatic do_lat(input string tag, input logic [4:0] v);
        step(tag, 1, 0, 0, '0, 0, '0, 0, '0, 1, v);
    endtask
    task automatic do_idle(input string tag);
        step(tag, 1, 0, 0, '0, 0, '0, 0, '0, 0, '0);
    endtask
    task automatic do_rst(input string tag);
        step(tag, 0, 1, 1, 8'hFF, 1, 11'h7FF, 1, 13'h1FFF, 1, 5'h1F);
    endtask

    initial begin
        // R1: reset state, latch seen as zero through a low-byte write
        do_rst("R1");
        do_rst("R1");
        do_lo("R1", 8'hAB);

        // R3: every latch value against every data byte
        for (int lv = 0; lv < 32; lv++) begin
            do_lat("R9", 5'(lv));
            for (int d = 0; d < 256; d++) do_lo("R3", 8'(d));
        end

        // R4: all page selections, lower latch bits varied, strided targets
        for (int pg = 0; pg < 4; pg++) begin
            do_lat("R9", {2'(pg), 3'(pg * 3 + 1)});
            for (int t = 0; t < 2048; t += 7) do_jmp("R4", 11'(t));
            do_jmp("R4", 11'h7FF);
        end

        // R5: returns across the address space, then latch survival
        for (int a = 0; a < 8192; a += 3) do_ret("R5", 13'(a));
        do_lat("R9", 5'h15);
        do_ret("R5", 13'h0123);
        do_ret("R5", 13'h1F00);
        do_lo("R5", 8'h00);

        // R6: carry into the page bits and wrap at the top
        do_ret("R6", 13'h00FE);
        do_inc("R6");
        do_inc("R6");
        do_ret("R6", 13'h1FFF);
        do_inc("R6");
        for (int k = 0; k < 300; k++) do_inc("R6");

        // R7: idle holds
        do_ret("R7", 13'h0A5A);
        for (int k = 0; k < 5; k++) do_idle("R7");

        // R8: all strobe combinations from a known state
        do_lat("R8", 5'h0B);
        for (int c = 0; c < 16; c++) begin
            do_ret("R8", 13'h1234);
            step("R8", 1, c[0], c[1], 8'h5C, c[2], 11'h3C1, c[3], 13'h0777, 0, '0);
        end

        // R9: same-cycle latch write uses old value, later update new one
        do_lat("R9", 5'h03);
        step("R9", 1, 0, 1, 8'h44, 0, '0, 0, '0, 1, 5'h1C);
        do_lo("R9", 8'h45);
        step("R9", 1, 0, 0, '0, 1, 11'h001, 0, '0, 1, 5'h00);
        do_jmp("R9", 11'h001);

        // R1: reset in mid-run overrides all strobes
        do_ret("R1", 13'h1ABC);
        do_rst("R1");
        do_lo("R1", 8'h01);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule